// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises a periodic service pulse from software or from another controller. Each service pulse has to land inside an allowed window. Time is counted from the start of every window. The span below the window-open threshold is forbidden. The window closes at the timeout threshold. A service that comes too soon points to runaway execution, and a missing service points to a stall. Either case produces a one-cycle reset request and stores the reason in a cause code that stays set.

Software first loads the two thresholds while the block is still disarmed, then arms it. From that point each accepted service restarts the window. Arming cannot be undone except by a system reset, and the thresholds are frozen while the block is armed. A threshold pair whose open value is not below its timeout is refused and reported on a flag.

Top module: `window_watchdog`

## Requirements
- R1: After reset the block is disarmed (`armed`=0), `wdg_reset_req`=0, `fault_cause`=2'b00 and `cfg_error`=0. While disarmed it never raises `wdg_reset_req`, whatever `service` does.
- R2: A `service` pulse sampled while the window count is below the open threshold is an early fault. `wdg_reset_req` goes high on the next cycle and `fault_cause` becomes 2'b01.
- R3: A `service` pulse sampled at a count from the open threshold up to the timeout minus one is accepted. It raises no reset request, and the next cycle starts a fresh window at count zero.
- R4: If the count reaches the timeout threshold with no service, a late fault occurs. `wdg_reset_req` goes high on the next cycle and `fault_cause` becomes 2'b10.
- R5: A `service` pulse sampled in the same cycle as the timeout counts as a late fault (2'b10), not as an accepted service.
- R6: `wdg_reset_req` is a single-cycle pulse, and every fault starts a fresh window at count zero.
- R7: `fault_cause` holds its value until `cause_clear` is pulsed, which sets it to 2'b00. A newer fault overwrites it. A fault in the same cycle as `cause_clear` takes priority over the clear.
- R8: A threshold write (`cfg_write`) while armed is ignored: the thresholds and `cfg_error` are unchanged.
- R9: A write while disarmed with `cfg_open` >= `cfg_timeout` is rejected: the thresholds keep their old values and `cfg_error` goes to 1. A valid write loads both thresholds and clears `cfg_error`.
- R10: An `arm` pulse sets `armed` on the next cycle. `armed` then stays 1 until system reset, and further `arm` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| arm | input | 1 | One-way enable pulse |
| service | input | 1 | Single-cycle service pulse |
| cause_clear | input | 1 | Clears the stored fault cause |
| cfg_write | input | 1 | Threshold write strobe |
| cfg_open | input | CNT_W | Window-open threshold to write |
| cfg_timeout | input | CNT_W | Timeout threshold to write |
| armed | output | 1 | Watchdog running |
| wdg_reset_req | output | 1 | One-cycle reset request |
| fault_cause | output | 2 | 00 none, 01 early, 10 late |
| cfg_error | output | 1 | Last write while disarmed was rejected |

## Verification
Every result is registered once. The reset request, the cause code, the armed flag and the configuration flag are therefore all due one clock after the edge that samples the stimulus. The window count is zero in the cycle after arming or after any event, and a timeout shows up exactly timeout+1 cycles after a window starts. The bench drives inputs on the falling edge, moves in whole-cycle steps, and reads outputs on the falling edge after the deciding rising edge. It also checks that the request is absent one step before it is due and gone one step after it fires.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10
  } cause_e;

  // count sits in the forbidden part of the window
  function automatic logic in_forbidden(input logic [31:0] count, input logic [31:0] open_thr);
    return count < open_thr;
  endfunction

  // count has reached the end of the window
  function automatic logic at_timeout(input logic [31:0] count, input logic [31:0] tmo_thr);
    return count >= tmo_thr;
  endfunction

  // a threshold pair is usable only if it leaves a non-empty window
  function automatic logic thresholds_ok(input logic [31:0] open_thr, input logic [31:0] tmo_thr);
    return open_thr < tmo_thr;
  endfunction

endpackage

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl
  import wwdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DEF_OPEN  = 8,
  parameter int DEF_LIMIT = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             cfg_write,
  input  logic [CNT_W-1:0] cfg_open,
  input  logic [CNT_W-1:0] cfg_timeout,
  output logic             armed,
  output logic [CNT_W-1:0] open_q,
  output logic [CNT_W-1:0] limit_q,
  output logic             cfg_error
);

  localparam logic [CNT_W-1:0] RST_OPEN  = CNT_W'(DEF_OPEN);
  localparam logic [CNT_W-1:0] RST_LIMIT = CNT_W'(DEF_LIMIT);

  logic write_allowed;
  logic write_good;
  logic write_bad;

  assign write_allowed = cfg_write && !armed;
  assign write_good    = write_allowed && thresholds_ok(32'(cfg_open), 32'(cfg_timeout));
  assign write_bad     = write_allowed && !write_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      open_q    <= RST_OPEN;
      limit_q   <= RST_LIMIT;
      cfg_error <= 1'b0;
    end else begin
      if (arm) armed <= 1'b1;
      if (write_good) begin
        open_q    <= cfg_open;
        limit_q   <= cfg_timeout;
        cfg_error <= 1'b0;
      end else if (write_bad) begin
        cfg_error <= 1'b1;
      end
    end
  end

  a_r10_arm_one_way: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    armed |=> ($stable(open_q) && $stable(limit_q) && $stable(cfg_error)));

  a_r9_cfg_order: assert property (@(posedge clk) disable iff (rst)
    open_q < limit_q);

endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             service,
  input  logic [CNT_W-1:0] open_q,
  input  logic [CNT_W-1:0] limit_q,
  output logic [CNT_W-1:0] count,
  output logic             early_evt,
  output logic             late_evt,
  output logic             ok_evt
);

  logic tmo_hit;
  logic forbidden;
  logic any_evt;

  assign tmo_hit   = armed && at_timeout(32'(count), 32'(limit_q));
  assign forbidden = in_forbidden(32'(count), 32'(open_q));
  // timeout wins over a coincident service
  assign late_evt  = tmo_hit;
  assign early_evt = armed && service && !tmo_hit && forbidden;
  assign ok_evt    = armed && service && !tmo_hit && !forbidden;
  assign any_evt   = early_evt || late_evt || ok_evt;

  always_ff @(posedge clk) begin
    if (rst || !armed) count <= '0;
    else if (any_evt)  count <= '0;
    else               count <= count + 1'b1;
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    armed |-> (count <= limit_q));

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    ok_evt |=> (count == '0));

endmodule

// File: rtl/wwdt_report.sv
module wwdt_report
  import wwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       early_evt,
  input  logic       late_evt,
  input  logic       cause_clear,
  output logic       wdg_reset_req,
  output logic [1:0] fault_cause
);

  cause_e cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdg_reset_req <= 1'b0;
      cause_q       <= CAUSE_NONE;
    end else begin
      wdg_reset_req <= early_evt || late_evt;
      if (early_evt)        cause_q <= CAUSE_EARLY;
      else if (late_evt)    cause_q <= CAUSE_LATE;
      else if (cause_clear) cause_q <= CAUSE_NONE;
    end
  end

  assign fault_cause = cause_q;

  a_r2_early_cause: assert property (@(posedge clk) disable iff (rst)
    early_evt |=> (wdg_reset_req && fault_cause == CAUSE_EARLY));

  a_r4_late_cause: assert property (@(posedge clk) disable iff (rst)
    late_evt |=> (wdg_reset_req && fault_cause == CAUSE_LATE));

  a_r7_cause_hold: assert property (@(posedge clk) disable iff (rst)
    (!early_evt && !late_evt && !cause_clear) |=> $stable(fault_cause));

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DEF_OPEN  = 8,
  parameter int DEF_LIMIT = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             service,
  input  logic             cause_clear,
  input  logic             cfg_write,
  input  logic [CNT_W-1:0] cfg_open,
  input  logic [CNT_W-1:0] cfg_timeout,
  output logic             armed,
  output logic             wdg_reset_req,
  output logic [1:0]       fault_cause,
  output logic             cfg_error
);

  logic [CNT_W-1:0] open_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] win_count;
  logic             early_evt;
  logic             late_evt;
  logic             ok_evt;

  wwdt_ctrl #(
    .CNT_W(CNT_W), .DEF_OPEN(DEF_OPEN), .DEF_LIMIT(DEF_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .cfg_write(cfg_write),
    .cfg_open(cfg_open), .cfg_timeout(cfg_timeout),
    .armed(armed), .open_q(open_q), .limit_q(limit_q), .cfg_error(cfg_error)
  );

  wwdt_window #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst(rst), .armed(armed), .service(service),
    .open_q(open_q), .limit_q(limit_q), .count(win_count),
    .early_evt(early_evt), .late_evt(late_evt), .ok_evt(ok_evt)
  );

  wwdt_report u_report (
    .clk(clk), .rst(rst), .early_evt(early_evt), .late_evt(late_evt),
    .cause_clear(cause_clear), .wdg_reset_req(wdg_reset_req),
    .fault_cause(fault_cause)
  );

  a_r1_quiet_disarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !wdg_reset_req);

  a_r6_fault_restarts: assert property (@(posedge clk) disable iff (rst)
    wdg_reset_req |-> (win_count == '0));

  a_r5_tie_is_late: assert property (@(posedge clk) disable iff (rst)
    (armed && service && win_count == limit_q) |=> (fault_cause == CAUSE_LATE));

endmodule

// File: tb/window_watchdog_tb.sv
`timescale 1ns/1ps
module window_watchdog_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             arm = 1'b0;
  logic             service = 1'b0;
  logic             cause_clear = 1'b0;
  logic             cfg_write = 1'b0;
  logic [CNT_W-1:0] cfg_open = '0;
  logic [CNT_W-1:0] cfg_timeout = '0;
  logic             armed;
  logic             wdg_reset_req;
  logic [1:0]       fault_cause;
  logic             cfg_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  window_watchdog #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .arm(arm), .service(service),
    .cause_clear(cause_clear), .cfg_write(cfg_write),
    .cfg_open(cfg_open), .cfg_timeout(cfg_timeout),
    .armed(armed), .wdg_reset_req(wdg_reset_req),
    .fault_cause(fault_cause), .cfg_error(cfg_error)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int o, input int t);
    cfg_open = CNT_W'(o); cfg_timeout = CNT_W'(t); cfg_write = 1'b1;
    step();
    cfg_write = 1'b0;
  endtask

  task automatic pulse_service();
    service = 1'b1;
    step();
    service = 1'b0;
  endtask

  task automatic clear_cause();
    cause_clear = 1'b1;
    step();
    cause_clear = 1'b0;
  endtask

  // R1: reset state and silence while disarmed
  task automatic t_reset();
    bit seen = 0;
    chk("R1", "armed", armed, 0);
    chk("R1", "reset_req", wdg_reset_req, 0);
    chk("R1", "cause", fault_cause, 0);
    chk("R1", "cfg_error", cfg_error, 0);
    for (int i = 0; i < 40; i++) begin
      service = (i % 3 == 0);
      step();
      if (wdg_reset_req) seen = 1;
    end
    service = 1'b0;
    chk("R1", "req while disarmed", seen, 0);
  endtask

  // R9: rejected and accepted threshold writes (open=4, timeout=10 kept)
  task automatic t_config();
    write_cfg(3, 3);
    chk("R9", "cfg_error equal pair", cfg_error, 1);
    write_cfg(4, 10);
    chk("R9", "cfg_error valid write", cfg_error, 0);
    write_cfg(12, 5);
    chk("R9", "cfg_error inverted pair", cfg_error, 1);
  endtask

  // R10: arming; leaves the window at count 0
  task automatic t_arm();
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R10", "armed after arm", armed, 1);
  endtask

  // R3/R4/R6 (and R9 retained thresholds): accepted services restart, then timeout
  task automatic t_accept_then_timeout();
    idle(4);
    pulse_service();
    chk("R3", "req at open edge", wdg_reset_req, 0);
    chk("R3", "cause at open edge", fault_cause, 0);
    idle(9);
    pulse_service();
    chk("R3", "req at timeout-1 (R9 old timeout kept)", wdg_reset_req, 0);
    idle(10);
    chk("R3", "no timeout before full window after accept", wdg_reset_req, 0);
    step();
    chk("R4", "req at timeout", wdg_reset_req, 1);
    chk("R4", "cause late", fault_cause, 2);
    step();
    chk("R6", "req single cycle after late", wdg_reset_req, 0);
    // now at count 1
  endtask

  // R7 clear, R2 early, R6 pulse width, R7 hold and overwrite
  task automatic t_early();
    clear_cause();
    chk("R7", "cause cleared", fault_cause, 0);
    // count is 2 here
    pulse_service();
    chk("R2", "req early", wdg_reset_req, 1);
    chk("R2", "cause early", fault_cause, 1);
    step();
    chk("R6", "req single cycle after early", wdg_reset_req, 0);
    // count 1
    idle(9);
    chk("R7", "cause held", fault_cause, 1);
    chk("R6", "window restarted after early", wdg_reset_req, 0);
    step();
    chk("R7", "late overwrites early", fault_cause, 2);
    chk("R4", "req late after early window", wdg_reset_req, 1);
    // count 0
  endtask

  // R5: service coinciding with the timeout
  task automatic t_tie();
    clear_cause();
    idle(9);
    pulse_service();
    chk("R5", "req on tie", wdg_reset_req, 1);
    chk("R5", "cause on tie", fault_cause, 2);
  endtask

  // R7: fault beats clear in the same cycle
  task automatic t_priority();
    cause_clear = 1'b1;
    service = 1'b1;
    step();
    cause_clear = 1'b0;
    service = 1'b0;
    chk("R7", "fault wins over clear", fault_cause, 1);
    chk("R2", "req on early at count 0", wdg_reset_req, 1);
  endtask

  // R8: writes while armed are ignored
  task automatic t_locked();
    clear_cause();
    write_cfg(1, 3);
    chk("R8", "cfg_error unchanged", cfg_error, 1);
    // count 2: early under open=4, accepted if 1/3 had been loaded
    pulse_service();
    chk("R8", "thresholds kept, service early", fault_cause, 1);
    chk("R8", "thresholds kept, req", wdg_reset_req, 1);
  endtask

  // R10: re-arm has no effect, only reset disarms
  task automatic t_arm_sticky();
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R10", "armed stays", armed, 1);
    idle(3);
    chk("R10", "armed still set", armed, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R10", "reset disarms", armed, 0);
    chk("R1", "cause after reset", fault_cause, 0);
    chk("R1", "cfg_error after reset", cfg_error, 0);
  endtask

  initial begin
    @(negedge clk);
    idle(3);
    rst = 1'b0;
    t_reset();
    t_config();
    t_arm();
    t_accept_then_timeout();
    t_early();
    t_tie();
    t_priority();
    t_locked();
    t_arm_sticky();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule